// File: doc/BRIEF.md
# Slow-Domain Real-Time Counter Core

This block is the counting core of a real-time counter that lives entirely in a slow clock domain. A 24-bit up-counter advances once per slow-clock edge while enabled. By default it runs through the full binary range and returns to zero. A control input can select compare value 0 as the wrap point instead, which gives a programmable period. Two compare values raise sticky event flags when the count reaches them. A wrap raises a third flag. The flags are masked by an interrupt-enable vector and combined into a single interrupt line.

All configuration arrives as levels that have already been synchronized into the slow domain: the enable, the debug-run choice, the top-select, both compare values, the interrupt enables and a write-one-to-clear strobe for the flags. A debugger-halt input freezes the count unless debug-run is set. Dropping the enable clears the count, so enabling it again restarts the count from zero.

Top module: `lf_rtc_core`

## Requirements
- R1: While rst_ni is low, count_o is zero, flags_o is zero and irq_o is low, whatever the interrupt enables are.
- R2: When run_en_i is high and counting is not halted, count_o increases by one on each clk_i rising edge until it reaches its wrap point.
- R3: With top_sel_i low, a count of all ones (0xFFFFFF at the default width) becomes zero on the next advancing edge. On that same edge, flags_o bit 0 (wrap flag) sets.
- R4: With top_sel_i high, a count equal to cmp0_i becomes zero on the next advancing edge, and flags_o bit 0 sets. If the count is already above cmp0_i, it keeps counting up to all ones and wraps there.
- R5: While run_en_i is low, the count is forced to zero on each edge. After run_en_i rises again, the first advancing edge gives a count of one.
- R6: While dbg_halt_i is high and dbg_run_i is low, count_o holds its value and no flag sets. While dbg_halt_i and dbg_run_i are both high, counting continues.
- R7: flags_o bit 1 sets on the advancing edge at which the count becomes equal to cmp0_i. flags_o bit 2 sets in the same way for cmp1_i.
- R8: Flags stay set until cleared. A one in flag_clr_i clears the matching flag on the next edge. If a set event and a clear for the same flag fall in the same cycle, the flag ends up set.
- R9: irq_o is high exactly when some bit is set in both flags_o and irq_en_i. It follows changes of irq_en_i without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slow clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_en_i | input | 1 | Count enable; low clears the count |
| dbg_run_i | input | 1 | Keep counting while the debugger halts |
| top_sel_i | input | 1 | Use cmp0_i as the wrap point |
| dbg_halt_i | input | 1 | Debugger halt request |
| cmp0_i | input | 24 | Compare value 0 |
| cmp1_i | input | 24 | Compare value 1 |
| irq_en_i | input | 3 | Interrupt enables {cmp1, cmp0, wrap} |
| flag_clr_i | input | 3 | Write-one-to-clear strobe for the flags |
| count_o | output | 24 | Current count |
| flags_o | output | 3 | Sticky flags {cmp1, cmp0, wrap} |
| irq_o | output | 1 | Masked interrupt |

## Verification
The bench goes after the wrap points. It covers the full-scale wrap, the wrap at compare 0, and the case where compare 0 is lowered below the current count. A design that compared with "greater or equal" would wrap early in that last case, and one that ignored the full-scale limit would never wrap. It checks that a halt without debug-run freezes both the count and the compare flags, and that re-enabling restarts from zero rather than resuming. A design that let clear beat a simultaneous set would drop that event, and the bench looks for this directly.

// File: rtl/lf_rtc_pkg.sv
package lf_rtc_pkg;
  localparam int NUM_CMP  = 2;
  localparam int FLAG_W   = NUM_CMP + 1;
  localparam int FLG_WRAP = 0;
  localparam int FLG_CMP0 = 1;
endpackage

// File: rtl/lf_rtc_count.sv
module lf_rtc_count #(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             tick_i,
  input  logic             top_sel_i,
  input  logic [CNT_W-1:0] top_val_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] nxt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] FULL = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             at_end;

  // wrap at full scale always, so a lowered top never strands the count
  assign at_end = (cnt_q == FULL) || (top_sel_i && (cnt_q == top_val_i));
  assign nxt_o  = at_end ? '0 : cnt_q + 1'b1;
  assign wrap_o = tick_i && at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!enable_i) cnt_q <= '0;
    else if (tick_i)    cnt_q <= nxt_o;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/lf_rtc_match.sv
module lf_rtc_match #(
  parameter int CNT_W = 24,
  parameter int N     = 2
) (
  input  logic                    adv_i,
  input  logic [CNT_W-1:0]        nxt_i,
  input  logic [N-1:0][CNT_W-1:0] cmp_i,
  output logic [N-1:0]            hit_o
);
  // a hit marks the edge on which the count becomes equal to the compare
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_o[g] = adv_i && (nxt_i == cmp_i[g]);
  end
endmodule

// File: rtl/lf_rtc_flags.sv
module lf_rtc_flags #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] irq_en_i,
  output logic [W-1:0] flags_o,
  output logic         irq_o
);
  logic [W-1:0] flg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flg_q <= '0;
    else         flg_q <= (flg_q & ~clr_i) | set_i;  // set beats clear
  end

  assign flags_o = flg_q;
  assign irq_o   = |(flg_q & irq_en_i);
endmodule

// File: rtl/lf_rtc_core.sv
module lf_rtc_core
  import lf_rtc_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_en_i,
  input  logic              dbg_run_i,
  input  logic              top_sel_i,
  input  logic              dbg_halt_i,
  input  logic [CNT_W-1:0]  cmp0_i,
  input  logic [CNT_W-1:0]  cmp1_i,
  input  logic [FLAG_W-1:0] irq_en_i,
  input  logic [FLAG_W-1:0] flag_clr_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              irq_o
);
  logic                          tick;
  logic                          wrap_evt;
  logic [CNT_W-1:0]              nxt_cnt;
  logic [NUM_CMP-1:0][CNT_W-1:0] cmp_vec;
  logic [NUM_CMP-1:0]            cmp_hit;
  logic [FLAG_W-1:0]             set_vec;

  assign tick    = run_en_i && (!dbg_halt_i || dbg_run_i);
  assign cmp_vec = {cmp1_i, cmp0_i};

  lf_rtc_count #(.CNT_W(CNT_W)) i_count (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .enable_i  (run_en_i),
    .tick_i    (tick),
    .top_sel_i (top_sel_i),
    .top_val_i (cmp0_i),
    .count_o   (count_o),
    .nxt_o     (nxt_cnt),
    .wrap_o    (wrap_evt)
  );

  lf_rtc_match #(.CNT_W(CNT_W), .N(NUM_CMP)) i_match (
    .adv_i (tick),
    .nxt_i (nxt_cnt),
    .cmp_i (cmp_vec),
    .hit_o (cmp_hit)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[FLG_WRAP] = wrap_evt;
    set_vec[FLG_CMP0 +: NUM_CMP] = cmp_hit;
  end

  lf_rtc_flags #(.W(FLAG_W)) i_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_vec),
    .clr_i    (flag_clr_i),
    .irq_en_i (irq_en_i),
    .flags_o  (flags_o),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/lf_rtc_core_chk.sv
module lf_rtc_core_chk
  import lf_rtc_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              run_en_i,
  input logic              dbg_run_i,
  input logic              top_sel_i,
  input logic              dbg_halt_i,
  input logic [CNT_W-1:0]  cmp0_i,
  input logic [CNT_W-1:0]  cmp1_i,
  input logic [FLAG_W-1:0] irq_en_i,
  input logic [FLAG_W-1:0] flag_clr_i,
  input logic [CNT_W-1:0]  count_o,
  input logic [FLAG_W-1:0] flags_o,
  input logic              irq_o
);
  localparam logic [CNT_W-1:0] FULL = '1;

  logic adv;
  assign adv = run_en_i && (!dbg_halt_i || dbg_run_i);

  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && count_o != FULL && !(top_sel_i && count_o == cmp0_i))
      |=> count_o == $past(count_o) + 1'b1); // R2

  AST_FULL_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && count_o == FULL) |=> (count_o == '0) && flags_o[FLG_WRAP]); // R3

  AST_TOP_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && top_sel_i && count_o == cmp0_i) |=> (count_o == '0) && flags_o[FLG_WRAP]); // R4

  AST_DISABLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_en_i |=> count_o == '0); // R5

  AST_HALT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_en_i && dbg_halt_i && !dbg_run_i) |=> $stable(count_o)); // R6

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flags_o & $past(flags_o & ~flag_clr_i)) == $past(flags_o & ~flag_clr_i))); // R8

  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en_i == '0) |-> !irq_o); // R9
endmodule

bind lf_rtc_core lf_rtc_core_chk #(.CNT_W(CNT_W)) i_chk (.*);

// File: tb/test_lf_rtc_core.sv
`timescale 1ns/1ps
module test_lf_rtc_core;
  localparam int W = 8;

  typedef struct packed {
    logic       en;
    logic       halt;
    logic       drun;
    logic       tsel;
    logic [7:0] c0;
    logic [7:0] ncyc;
    logic [7:0] exp_cnt;
    logic [2:0] exp_flg;
    logic [3:0] req;
  } vec_t;

  // cmp1 held at 200 throughout the table; flags accumulate
  localparam vec_t TBL [11] = '{
    '{1'b1, 1'b0, 1'b0, 1'b0, 8'd5, 8'd3,   8'd3,   3'b000, 4'd2},
    '{1'b1, 1'b0, 1'b0, 1'b0, 8'd5, 8'd2,   8'd5,   3'b010, 4'd7},
    '{1'b1, 1'b1, 1'b0, 1'b0, 8'd5, 8'd4,   8'd5,   3'b010, 4'd6},
    '{1'b1, 1'b1, 1'b1, 1'b0, 8'd5, 8'd2,   8'd7,   3'b010, 4'd6},
    '{1'b0, 1'b0, 1'b0, 1'b0, 8'd5, 8'd1,   8'd0,   3'b010, 4'd5},
    '{1'b1, 1'b0, 1'b0, 1'b0, 8'd5, 8'd1,   8'd1,   3'b010, 4'd5},
    '{1'b1, 1'b0, 1'b0, 1'b1, 8'd5, 8'd5,   8'd0,   3'b011, 4'd4},
    '{1'b1, 1'b0, 1'b0, 1'b1, 8'd5, 8'd3,   8'd3,   3'b011, 4'd4},
    '{1'b1, 1'b0, 1'b0, 1'b1, 8'd1, 8'd2,   8'd5,   3'b011, 4'd4},
    '{1'b1, 1'b0, 1'b0, 1'b0, 8'd1, 8'd195, 8'd200, 3'b111, 4'd7},
    '{1'b1, 1'b0, 1'b0, 1'b0, 8'd1, 8'd56,  8'd0,   3'b111, 4'd3}
  };

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         run_en_i = 1'b0, dbg_run_i = 1'b0, top_sel_i = 1'b0, dbg_halt_i = 1'b0;
  logic [W-1:0] cmp0_i = '0, cmp1_i = '0, count_o;
  logic [2:0]   irq_en_i = '0, flag_clr_i = '0, flags_o;
  logic         irq_o;
  int           errors = 0, checks = 0;
  logic         done = 1'b0;

  always #4 clk_i = ~clk_i;

  lf_rtc_core #(.CNT_W(W)) i_lf_rtc_core (.*);

  task automatic step(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    irq_en_i = 3'b111;
    step(3);
    chk("R1 count", count_o, 0);
    chk("R1 flags", flags_o, 0);
    chk("R1 irq", irq_o, 0);
    irq_en_i = '0;
    rst_ni = 1'b1;
    cmp1_i = 8'd200;
    step(1);

    foreach (TBL[i]) begin
      run_en_i = TBL[i].en; dbg_halt_i = TBL[i].halt;
      dbg_run_i = TBL[i].drun; top_sel_i = TBL[i].tsel; cmp0_i = TBL[i].c0;
      step(int'(TBL[i].ncyc));
      chk($sformatf("R%0d count vec%0d", TBL[i].req, i), count_o, TBL[i].exp_cnt);
      chk($sformatf("R%0d flags vec%0d", TBL[i].req, i), flags_o, TBL[i].exp_flg);
    end

    // R8 clear all, R5 disabled count
    run_en_i = 1'b0; flag_clr_i = 3'b111; top_sel_i = 1'b0;
    step(1);
    chk("R8 clear", flags_o, 0);
    chk("R5 disabled", count_o, 0);
    flag_clr_i = '0;

    // R3 full-scale wrap, R7 both compares at 100
    cmp0_i = 8'd100; cmp1_i = 8'd100; run_en_i = 1'b1;
    step(255);
    chk("R3 at full", count_o, 255);
    chk("R7 both hit, no early wrap R3", flags_o, 3'b110);
    step(1);
    chk("R3 wrapped", count_o, 0);
    chk("R3 wrap flag", flags_o, 3'b111);

    // R8 set wins over clear
    run_en_i = 1'b0; flag_clr_i = 3'b111;
    step(1);
    run_en_i = 1'b1; cmp0_i = 8'd1; flag_clr_i = 3'b010;
    step(1);
    chk("R8 set wins count", count_o, 1);
    chk("R8 set wins", flags_o, 3'b010);
    flag_clr_i = '0;

    // R9 masking, combinational
    irq_en_i = 3'b010; #1;
    chk("R9 enabled", irq_o, 1);
    irq_en_i = 3'b001; #1;
    chk("R9 masked", irq_o, 0);

    // R6 halt freezes count and flags
    cmp1_i = 8'd2; dbg_halt_i = 1'b1; dbg_run_i = 1'b0;
    step(2);
    chk("R6 halt count", count_o, 1);
    chk("R6 halt flags", flags_o, 3'b010);

    irq_en_i = 3'b111; flag_clr_i = 3'b111;
    step(1);
    chk("R9 cleared", irq_o, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule